// File: doc/BRIEF.md
# Buffered Page Program Sequencer

This block writes a byte range of any start address and length into a serial flash that has an on-chip SRAM page buffer and non-power-of-two pages. It turns the linear start address into a page number and an in-page offset and cuts the range into chunks on page boundaries. For each chunk it drives command frames through a byte-wide SPI command port. A chunk that covers only part of a page first has the flash copy the old page into the buffer, so that the program step rewrites the untouched bytes with their old values. The program frame carries the address and then the chunk's data bytes, which it takes from a valid/ready stream.

After every command the sequencer reads the flash status byte until the device reports ready. When a request asks for verification, the sequencer has the flash compare the buffer against the page after each program step and stops with an error on a mismatch. A request ends with a one-cycle completion pulse, an error flag, and the number of bytes in chunks that completed.

The SPI shifter and the data source are outside this block. The port accepts one byte per `spi_tx_valid`/`spi_tx_ready` handshake and returns the byte clocked in during each transfer one cycle later on `spi_rx_valid`/`spi_rx_data`.

Top module: `flashprog_seq`

## Requirements
- R1: A request whose start address plus length exceeds the device size (PAGE_SIZE*NUM_PAGES) is answered on the next cycle with `done` and `err` high, `bytes_done` zero, and no SPI frame.
- R2: A request of length zero is answered on the next cycle with `done` high, `err` low, and no SPI frame.
- R3: The first chunk has the length min(length, PAGE_SIZE - offset). Each later chunk is a whole page, except a shorter last chunk. Each chunk moves on to the next page at offset zero.
- R4: Before a chunk shorter than PAGE_SIZE is programmed, a frame of opcode 0x53 and three address bytes is sent. The address is page<<PAGE_SHIFT, with the offset bits zero. A status poll follows this frame.
- R5: A program frame is opcode 0x82 and then three address bytes, most significant first, with the value (page<<PAGE_SHIFT)|offset. The chunk's data bytes follow in the same frame.
- R6: After each command frame the block polls the status. Each poll is its own frame: opcode 0xD7 and then one filler byte 0x00. The byte returned for the filler is the status, and polling repeats until bit 7 of the status is 1.
- R7: With `req_verify` set, each program step is followed by a frame of opcode 0x60 with the page address (offset bits zero) and a poll. If bit 6 of the final status is 1, the request ends with `done` and `err` high.
- R8: `spi_cs` stays high for every byte of a frame and drops for at least one cycle between frames. `spi_tx_valid` is high only while `spi_cs` is high.
- R9: `bytes_done` counts only the bytes of chunks that completed. On a request that succeeds it equals the request length.
- R10: A byte offered on `spi_tx_data` is held until it is accepted. Data bytes are taken from the stream only in the data phase of a program frame, and only when the shifter accepts them.
- R11: `done` is a single-cycle pulse. `req_ready` is high only while the block is idle, and the block is idle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a request (accepted when `req_ready` is high) |
| req_ready | output | 1 | Block is idle |
| req_addr | input | LIN_W | Linear start byte address |
| req_len | input | LIN_W | Number of bytes to write |
| req_verify | input | 1 | Run a compare after each program step |
| din_valid | input | 1 | Stream byte available |
| din_ready | output | 1 | Stream byte consumed this cycle |
| din_data | input | 8 | Stream byte |
| spi_cs | output | 1 | Frame select, high for the length of a frame |
| spi_tx_valid | output | 1 | Byte offered to the shifter |
| spi_tx_ready | input | 1 | Shifter takes the byte |
| spi_tx_data | output | 8 | Byte to shift out |
| spi_rx_valid | input | 1 | Byte received during the last transfer |
| spi_rx_data | input | 8 | Received byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request failed (valid with `done`) |
| bytes_done | output | LIN_W | Bytes in completed chunks |

## Verification
The bench targets a range that starts mid-page, crosses two page boundaries and ends short of a page. A design with the wrong chunk arithmetic would put data into the wrong page or skip the buffer load before a partial tail. A request that ends exactly at the top of the device and one that passes it by one byte separate an off-by-one range check from a correct one. A compare mismatch on the second chunk shows whether the byte count includes the aborted chunk. Polls that return busy several times, together with a shifter and a stream that stall, catch a sequencer that moves on before the device is ready or that drops or repeats bytes.

// File: rtl/flashprog_pkg.sv
package flashprog_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_LOCATE, S_PLAN, S_CMD, S_DATA, S_CGAP,
    S_POLL_OP, S_POLL_RD, S_POLL_WAIT, S_PGAP, S_NEXT, S_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    OPK_LOAD, OPK_PROG, OPK_CMP
  } op_kind_t;

  localparam logic [7:0] OPC_LOAD = 8'h53;
  localparam logic [7:0] OPC_PROG = 8'h82;
  localparam logic [7:0] OPC_CMP  = 8'h60;
  localparam logic [7:0] OPC_STAT = 8'hD7;
  localparam logic [7:0] FILLER   = 8'h00;

  localparam int RDY_BIT  = 7;
  localparam int MISM_BIT = 6;
  localparam int CMD_LEN  = 4;

endpackage

// File: rtl/flashprog_locate.sv
// Iterative page/offset split of a linear address (repeated subtraction).
module flashprog_locate #(
  parameter int PAGE_SIZE = 12,
  parameter int LIN_W     = 8,
  parameter int PG_W      = 4,
  parameter int OFF_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LIN_W-1:0] lin_addr,
  output logic             done,
  output logic [PG_W-1:0]  page,
  output logic [OFF_W-1:0] offset
);

  logic             run_q, run_d;
  logic             done_q, done_d;
  logic [LIN_W-1:0] rem_q, rem_d;
  logic [PG_W-1:0]  page_q, page_d;

  always_comb begin
    run_d  = run_q;
    done_d = 1'b0;
    rem_d  = rem_q;
    page_d = page_q;
    if (start) begin
      run_d  = 1'b1;
      rem_d  = lin_addr;
      page_d = '0;
    end else if (run_q) begin
      if (rem_q >= LIN_W'(PAGE_SIZE)) begin
        rem_d  = rem_q - LIN_W'(PAGE_SIZE);
        page_d = page_q + PG_W'(1);
      end else begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
      page_q <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      if (start || run_q) begin
        rem_q  <= rem_d;
        page_q <= page_d;
      end
    end
  end

  assign done   = done_q;
  assign page   = page_q;
  assign offset = rem_q[OFF_W-1:0];

endmodule

// File: rtl/flashprog_cmdbytes.sv
// Selects one byte of a four-byte command header.
module flashprog_cmdbytes
  import flashprog_pkg::*;
#(
  parameter int PG_W  = 4,
  parameter int OFF_W = 4
) (
  input  op_kind_t         kind,
  input  logic [PG_W-1:0]  page,
  input  logic [OFF_W-1:0] offset,
  input  logic [1:0]       idx,
  output logic [7:0]       cmd_byte
);

  logic [OFF_W-1:0] eff_off;
  logic [23:0]      flash_addr;
  logic [7:0]       opcode;

  always_comb begin
    unique case (kind)
      OPK_LOAD: opcode = OPC_LOAD;
      OPK_PROG: opcode = OPC_PROG;
      OPK_CMP:  opcode = OPC_CMP;
      default:  opcode = OPC_STAT;
    endcase
    eff_off    = (kind == OPK_PROG) ? offset : '0;
    flash_addr = 24'({page, eff_off});
    unique case (idx)
      2'd0:    cmd_byte = opcode;
      2'd1:    cmd_byte = flash_addr[23:16];
      2'd2:    cmd_byte = flash_addr[15:8];
      default: cmd_byte = flash_addr[7:0];
    endcase
  end

endmodule

// File: rtl/flashprog_seq.sv
module flashprog_seq
  import flashprog_pkg::*;
#(
  parameter int PAGE_SIZE  = 12,
  parameter int PAGE_SHIFT = 4,
  parameter int NUM_PAGES  = 16,
  localparam int DEV_SIZE  = PAGE_SIZE * NUM_PAGES,
  localparam int LIN_W     = $clog2(DEV_SIZE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LIN_W-1:0] req_addr,
  input  logic [LIN_W-1:0] req_len,
  input  logic             req_verify,
  input  logic             din_valid,
  output logic             din_ready,
  input  logic [7:0]       din_data,
  output logic             spi_cs,
  output logic             spi_tx_valid,
  input  logic             spi_tx_ready,
  output logic [7:0]       spi_tx_data,
  input  logic             spi_rx_valid,
  input  logic [7:0]       spi_rx_data,
  output logic             done,
  output logic             err,
  output logic [LIN_W-1:0] bytes_done
);

  localparam int PG_W  = $clog2(NUM_PAGES);
  localparam int OFF_W = PAGE_SHIFT;
  localparam int CHK_W = $clog2(PAGE_SIZE + 1);

  seq_state_t       state_q, state_d;
  op_kind_t         op_q, op_d;
  logic             verify_q, verify_d;
  logic             err_q, err_d;
  logic [LIN_W-1:0] rem_q, rem_d;
  logic [LIN_W-1:0] cnt_q, cnt_d;
  logic [PG_W-1:0]  page_q, page_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [CHK_W-1:0] chunk_q, chunk_d;
  logic [CHK_W-1:0] dcnt_q, dcnt_d;
  logic [1:0]       idx_q, idx_d;
  logic [7:0]       stat_q, stat_d;

  logic             loc_start, loc_done;
  logic [PG_W-1:0]  loc_page;
  logic [OFF_W-1:0] loc_off;
  logic [7:0]       hdr_byte;
  logic [LIN_W:0]   end_addr;
  logic             too_far;
  logic [CHK_W-1:0] room, chunk_len;
  logic             tx_acc;

  flashprog_locate #(
    .PAGE_SIZE (PAGE_SIZE),
    .LIN_W     (LIN_W),
    .PG_W      (PG_W),
    .OFF_W     (OFF_W)
  ) u_locate (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (loc_start),
    .lin_addr (req_addr),
    .done     (loc_done),
    .page     (loc_page),
    .offset   (loc_off)
  );

  flashprog_cmdbytes #(
    .PG_W  (PG_W),
    .OFF_W (OFF_W)
  ) u_cmdbytes (
    .kind     (op_q),
    .page     (page_q),
    .offset   (off_q),
    .idx      (idx_q),
    .cmd_byte (hdr_byte)
  );

  // request range and chunk arithmetic
  assign end_addr  = {1'b0, req_addr} + {1'b0, req_len};
  assign too_far   = end_addr > (LIN_W + 1)'(DEV_SIZE);
  assign room      = CHK_W'(PAGE_SIZE) - CHK_W'(off_q);
  assign chunk_len = (rem_q < LIN_W'(room)) ? CHK_W'(rem_q) : room;

  // port side
  always_comb begin
    spi_cs       = 1'b0;
    spi_tx_valid = 1'b0;
    spi_tx_data  = FILLER;
    unique case (state_q)
      S_CMD:       begin spi_cs = 1'b1; spi_tx_valid = 1'b1; spi_tx_data = hdr_byte; end
      S_DATA:      begin spi_cs = 1'b1; spi_tx_valid = din_valid; spi_tx_data = din_data; end
      S_POLL_OP:   begin spi_cs = 1'b1; spi_tx_valid = 1'b1; spi_tx_data = OPC_STAT; end
      S_POLL_RD:   begin spi_cs = 1'b1; spi_tx_valid = 1'b1; end
      S_POLL_WAIT: spi_cs = 1'b1;
      default:     ;
    endcase
  end

  assign tx_acc     = spi_tx_valid && spi_tx_ready;
  assign din_ready  = (state_q == S_DATA) && spi_tx_ready;
  assign req_ready  = (state_q == S_IDLE);
  assign done       = (state_q == S_DONE);
  assign err        = done && err_q;
  assign bytes_done = cnt_q;

  // next state
  always_comb begin
    state_d   = state_q;
    op_d      = op_q;
    verify_d  = verify_q;
    err_d     = err_q;
    rem_d     = rem_q;
    cnt_d     = cnt_q;
    page_d    = page_q;
    off_d     = off_q;
    chunk_d   = chunk_q;
    dcnt_d    = dcnt_q;
    idx_d     = idx_q;
    stat_d    = stat_q;
    loc_start = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_valid) begin
        cnt_d    = '0;
        err_d    = 1'b0;
        verify_d = req_verify;
        rem_d    = req_len;
        if (req_len == '0) begin
          state_d = S_DONE;
        end else if (too_far) begin
          err_d   = 1'b1;
          state_d = S_DONE;
        end else begin
          loc_start = 1'b1;
          state_d   = S_LOCATE;
        end
      end
      S_LOCATE: if (loc_done) begin
        page_d  = loc_page;
        off_d   = loc_off;
        state_d = S_PLAN;
      end
      S_PLAN: begin
        chunk_d = chunk_len;
        dcnt_d  = '0;
        idx_d   = '0;
        op_d    = (chunk_len != CHK_W'(PAGE_SIZE)) ? OPK_LOAD : OPK_PROG;
        state_d = S_CMD;
      end
      S_CMD: if (tx_acc) begin
        if (idx_q == 2'(CMD_LEN - 1)) begin
          state_d = (op_q == OPK_PROG) ? S_DATA : S_CGAP;
        end else begin
          idx_d = idx_q + 2'd1;
        end
      end
      S_DATA: if (tx_acc) begin
        if (dcnt_q == chunk_q - CHK_W'(1)) state_d = S_CGAP;
        else dcnt_d = dcnt_q + CHK_W'(1);
      end
      S_CGAP:    state_d = S_POLL_OP;
      S_POLL_OP: if (tx_acc) state_d = S_POLL_RD;
      S_POLL_RD: if (tx_acc) state_d = S_POLL_WAIT;
      S_POLL_WAIT: if (spi_rx_valid) begin
        stat_d  = spi_rx_data;
        state_d = S_PGAP;
      end
      S_PGAP: begin
        if (!stat_q[RDY_BIT]) begin
          state_d = S_POLL_OP;
        end else begin
          unique case (op_q)
            OPK_LOAD: begin op_d = OPK_PROG; idx_d = '0; state_d = S_CMD; end
            OPK_PROG: begin
              if (verify_q) begin op_d = OPK_CMP; idx_d = '0; state_d = S_CMD; end
              else state_d = S_NEXT;
            end
            default: begin
              if (stat_q[MISM_BIT]) begin err_d = 1'b1; state_d = S_DONE; end
              else state_d = S_NEXT;
            end
          endcase
        end
      end
      S_NEXT: begin
        cnt_d  = cnt_q + LIN_W'(chunk_q);
        rem_d  = rem_q - LIN_W'(chunk_q);
        page_d = page_q + PG_W'(1);
        off_d  = '0;
        state_d = (rem_q == LIN_W'(chunk_q)) ? S_DONE : S_PLAN;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      op_q     <= OPK_LOAD;
      verify_q <= 1'b0;
      err_q    <= 1'b0;
      rem_q    <= '0;
      cnt_q    <= '0;
      page_q   <= '0;
      off_q    <= '0;
      chunk_q  <= '0;
      dcnt_q   <= '0;
      idx_q    <= '0;
      stat_q   <= '0;
    end else begin
      state_q  <= state_d;
      op_q     <= op_d;
      verify_q <= verify_d;
      err_q    <= err_d;
      rem_q    <= rem_d;
      cnt_q    <= cnt_d;
      page_q   <= page_d;
      off_q    <= off_d;
      chunk_q  <= chunk_d;
      dcnt_q   <= dcnt_d;
      idx_q    <= idx_d;
      if (state_q == S_POLL_WAIT) stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/flashprog_seq_chk.sv
module flashprog_seq_chk #(
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [LW-1:0] req_len,
  input logic          done,
  input logic          err,
  input logic [LW-1:0] bytes_done,
  input logic          spi_cs,
  input logic          spi_tx_valid,
  input logic          spi_tx_ready,
  input logic [7:0]    spi_tx_data,
  input logic          din_ready
);

  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else if (req_valid && req_ready) len_q <= req_len;
  end

  a_r8_tx_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid |-> spi_cs);

  a_r10_din_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> spi_cs);

  a_r10_hold_tx: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid && !spi_tx_ready |=> spi_tx_valid && $stable(spi_tx_data));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_len == '0) |=> done && !err);

  a_r9_full_count: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> bytes_done == len_q);

endmodule

bind flashprog_seq flashprog_seq_chk #(.LW(LIN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_len      (req_len),
  .done         (done),
  .err          (err),
  .bytes_done   (bytes_done),
  .spi_cs       (spi_cs),
  .spi_tx_valid (spi_tx_valid),
  .spi_tx_ready (spi_tx_ready),
  .spi_tx_data  (spi_tx_data),
  .din_ready    (din_ready)
);

// File: tb/sim_flashprog_seq.sv
module sim_flashprog_seq;

  localparam int CLK_PERIOD = 10;
  localparam int PS   = 12;
  localparam int SH   = 4;
  localparam int NP   = 16;
  localparam int SIZE = PS * NP;
  localparam int LW   = $clog2(SIZE + 1);

  logic clk, rst_n;
  logic req_valid, req_ready, req_verify;
  logic [LW-1:0] req_addr, req_len, bytes_done;
  logic din_valid, din_ready;
  logic [7:0] din_data;
  logic spi_cs, spi_tx_valid, spi_tx_ready, spi_rx_valid;
  logic [7:0] spi_tx_data, spi_rx_data;
  logic done, err;

  int checks = 0;
  int fails  = 0;

  flashprog_seq #(.PAGE_SIZE(PS), .PAGE_SHIFT(SH), .NUM_PAGES(NP)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_verify(req_verify),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .spi_cs(spi_cs), .spi_tx_valid(spi_tx_valid), .spi_tx_ready(spi_tx_ready),
    .spi_tx_data(spi_tx_data), .spi_rx_valid(spi_rx_valid), .spi_rx_data(spi_rx_data),
    .done(done), .err(err), .bytes_done(bytes_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // scoreboard: {first byte of frame, byte}
  logic [8:0] exp_q[$];
  logic [7:0] src_q[$];

  int busy_cfg = 0, mm_idx = -1, busy_left = 0, cmp_seen = 0, cyc = 0;
  bit mism = 0, fresh = 1;
  logic [7:0] cur_op = 8'h00;
  int pos = 0;
  bit sn_cs = 0, sn_tx_acc = 0, sn_din_acc = 0, sn_din_valid = 0;
  logic [7:0] sn_tx_data = 8'h00;

  task automatic check(bit cond, string req, int act, int expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // flash model, stream source and monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      spi_tx_ready = 1'b0;
      spi_rx_valid = 1'b0;
      spi_rx_data  = 8'h00;
      din_valid    = 1'b0;
      din_data     = 8'h00;
      fresh = 1; sn_tx_acc = 0; sn_din_acc = 0; sn_din_valid = 0; sn_cs = 0;
    end else begin
      cyc++;
      spi_rx_valid = 1'b0;
      if (!sn_cs) fresh = 1;
      if (sn_tx_acc) begin
        bit first;
        first = fresh;
        fresh = 0;
        pos = first ? 0 : pos + 1;
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected SPI byte", int'(sn_tx_data), -1);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          // stream covers R3 R4 R5 R6 R7 R8
          check({first, sn_tx_data} == e, "R5 R4 R6 R8 byte stream",
                int'({first, sn_tx_data}), int'(e));
        end
        if (first) begin
          cur_op = sn_tx_data;
          if (sn_tx_data != 8'hD7) busy_left = busy_cfg;
          if (sn_tx_data == 8'h60) begin
            mism = (cmp_seen == mm_idx);
            cmp_seen++;
          end
        end
        spi_rx_valid = 1'b1;
        if (!first && cur_op == 8'hD7 && pos == 1) begin
          if (busy_left > 0) begin
            spi_rx_data = 8'h00;
            busy_left--;
          end else begin
            spi_rx_data = {1'b1, mism, 6'b0};
          end
        end else begin
          spi_rx_data = 8'h3F;
        end
      end
      if (sn_din_acc) void'(src_q.pop_front());
      spi_tx_ready = (cyc % 5) != 2;
      din_valid = (src_q.size() > 0) &&
                  ((sn_din_valid && !sn_din_acc) || ((cyc % 7) != 3));
      din_data  = (src_q.size() > 0) ? src_q[0] : 8'h00;
      #1;
      sn_cs        = spi_cs;
      sn_tx_acc    = spi_tx_valid && spi_tx_ready;
      sn_tx_data   = spi_tx_data;
      sn_din_acc   = din_valid && din_ready;
      sn_din_valid = din_valid;
    end
  end

  task automatic push_frame(logic [7:0] op, int a);
    exp_q.push_back({1'b1, op});
    exp_q.push_back({1'b0, 8'(a >> 16)});
    exp_q.push_back({1'b0, 8'(a >> 8)});
    exp_q.push_back({1'b0, 8'(a)});
  endtask

  task automatic push_polls(int busy);
    for (int i = 0; i <= busy; i++) begin
      exp_q.push_back({1'b1, 8'hD7});
      exp_q.push_back({1'b0, 8'h00});
    end
  endtask

  task automatic build(int addr, int len, bit ver, int busy, int mmi, int seed,
                       output int cnt, output bit e);
    int page, off, rem, c, cmpn, di;
    page = addr / PS; off = addr % PS; rem = len;
    cnt = 0; e = 0; cmpn = 0; di = 0;
    while (rem > 0) begin
      c = (rem < PS - off) ? rem : PS - off;
      if (c != PS) begin                        // R4 buffer load
        push_frame(8'h53, page << SH);
        push_polls(busy);
      end
      push_frame(8'h82, (page << SH) | off);    // R5
      for (int k = 0; k < c; k++) begin
        logic [7:0] d;
        d = 8'(seed + di * 7);
        di++;
        exp_q.push_back({1'b0, d});
        src_q.push_back(d);
      end
      push_polls(busy);                          // R6
      if (ver) begin                             // R7
        push_frame(8'h60, page << SH);
        push_polls(busy);
        if (cmpn == mmi) begin e = 1; break; end
        cmpn++;
      end
      cnt += c; rem -= c; page++; off = 0;      // R3 R9
    end
  endtask

  task automatic run(int addr, int len, bit ver, int busy, int mmi, int seed, string tag);
    int ecnt, waited;
    bit eerr;
    ecnt = 0; eerr = 0; waited = 0;
    if (len == 0) begin ecnt = 0; eerr = 0; end
    else if (addr + len > SIZE) begin ecnt = 0; eerr = 1; end
    else build(addr, len, ver, busy, mmi, seed, ecnt, eerr);
    busy_cfg = busy; mm_idx = mmi; cmp_seen = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    #2;
    req_valid  = 1'b1;
    req_addr   = LW'(addr);
    req_len    = LW'(len);
    req_verify = ver;
    @(negedge clk);
    #2;
    req_valid = 1'b0;
    while (!done) begin
      @(negedge clk);
      #2;
      waited++;
    end
    $display("run %s: done after %0d cycles", tag, waited);
    if (len == 0) check(waited == 0, "R2 zero-length latency", waited, 0);
    else if (addr + len > SIZE) check(waited == 0, "R1 reject latency", waited, 0);
    check(err == eerr, "R1 R7 err flag", int'(err), int'(eerr));
    check(int'(bytes_done) == ecnt, "R9 bytes_done", int'(bytes_done), ecnt);
    check(exp_q.size() == 0, "R3 frames outstanding", exp_q.size(), 0);
    check(src_q.size() == 0, "R10 stream bytes left", src_q.size(), 0);
    @(negedge clk);
    #2;
    check(!done && req_ready, "R11 done pulse", int'(done), 0);
    exp_q.delete();
    src_q.delete();
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_len = '0; req_verify = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(req_ready && !done, "R11 reset idle", int'(req_ready), 1);
    check(!spi_cs && !spi_tx_valid, "R8 reset no frame", int'(spi_cs), 0);
    run(24, 12, 0, 2, -1, 5,   "R5 full page");
    run(30, 4,  0, 0, -1, 17,  "R4 partial");
    run(40, 30, 1, 1, -1, 33,  "R3 spanning verify");
    run(0,  12, 1, 0, 0,  50,  "R7 mismatch first");
    run(6,  20, 1, 3, 1,  71,  "R9 mismatch second");
    run(180, 12, 0, 1, -1, 90, "R1 top page");
    run(180, 13, 0, 0, -1, 0,  "R1 over end");
    run(0,  0,  0, 0, -1, 0,   "R2 zero length");
    run(191, 1, 1, 4, -1, 200, "R6 last byte");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule